// File: doc/BRIEF.md
# Threshold-Gated Posted Write Buffer

This block sits between a slower bus target that accepts write data and a faster processor-side bus master that forwards the data. Incoming write beats go into a 64-entry FIFO through a valid/ready stream. The target side can keep filling the FIFO while the master side empties earlier data, so the two sides overlap. The master side does not forward each beat as it arrives. It asks for the processor bus only when enough data is buffered, then moves a whole cache line (8 beats of 32 bits) in one burst.

Two configuration inputs control when a request may be raised. An enable bit turns posting on or off. A 2-bit level field sets how many cache lines must be buffered before the first burst of a transfer. Bursts that follow the first one need only a single buffered line. With posting off, every beat goes out on its own as soon as it is buffered. When the incoming transaction ends with less than a line left, the remainder is flushed beat by beat. The configuration is taken only while the buffer is empty and the master side is idle.

Back-pressure on the input stream works as follows. A beat transfers on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` falls when the FIFO is full, or once the final beat of a transaction has been taken and is still waiting to be flushed. A source must hold its beat stable until the beat is accepted. The output side has no ready signal: once a grant is taken, the processor bus accepts one beat per cycle.

Top module: `posted_write_buffer`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `bus_req` and `out_valid` are 0.
- R2: Beats leave on `out_data` in exactly the order in which they were accepted, with none lost or repeated, and `out_valid` is never high while the buffer is empty.
- R3: With 64 entries held, `in_ready` is 0. A beat that is offered while the buffer is full waits and is accepted once a drain frees space.
- R4: With posting enabled, the first request of a transfer is raised only when the buffer holds at least 32, 24, 16 or 8 entries, for level codes 00, 01, 10 and 11 respectively.
- R5: With posting enabled, once the first burst is done, a new request is raised as soon as 8 or more entries are held, whatever the level code.
- R6: With posting enabled and the threshold met, each granted burst is 8 consecutive beats, and `out_last` is high on the eighth.
- R7: With posting disabled (enable bit 0), a request is raised as soon as one entry is held, whatever the level code, and every granted transfer is one beat with `out_last` high.
- R8: Accepting a beat with `in_last` = 1 starts a flush. The remainder drains as 8-beat bursts while at least 8 entries are held, then as single beats. `in_ready` stays 0 from that acceptance until the buffer is empty.
- R9: The enable bit and level code are sampled only while the buffer is empty and the master side is idle. A change at any other time has no effect on the transfer in progress.
- R10: `bus_req` stays high until `bus_gnt` is sampled high. The first beat appears in the cycle after that edge, and `bus_req` is low during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_post_en | input | 1 | 1 = posting with line bursts, 0 = single-beat transfers |
| cfg_start_lvl | input | 2 | First-burst fill level code (00 = 4 lines ... 11 = 1 line) |
| in_valid | input | 1 | Incoming write beat is valid |
| in_data | input | DATA_W | Incoming write data |
| in_last | input | 1 | Beat is the final one of the incoming transaction |
| in_ready | output | 1 | Buffer can take a beat this cycle |
| bus_req | output | 1 | Request for the processor-side bus |
| bus_gnt | input | 1 | Grant for the processor-side bus |
| out_valid | output | 1 | Outgoing beat on the processor-side bus |
| out_data | output | DATA_W | Outgoing write data |
| out_last | output | 1 | Final beat of the current burst or single transfer |

## Verification
The bound checker watches several properties on every cycle:
- the full-buffer stall and the absence of any beat from an empty buffer;
- a request held until it is granted, and the first beat following a grant;
- configuration that does not move outside an empty, idle window;
- single-beat transfers in non-posted mode.

Other behaviour can only be shown by the bench scenarios. These cover the exact fill level at which each level code first raises a request, the rule that continuation needs only one line, the split of a flushed remainder into lines and single beats, and the end-to-end order of the data. The bench sweeps both enable settings and all four level codes, adding fill-by-fill checks of the request.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

  // Drain-side sequencer states
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_REQ   = 2'd1,
    MS_BURST = 2'd2
  } mst_state_e;

  // Number of level codes carried by the 2-bit start field
  localparam int unsigned LVL_CODES = 4;

endpackage

// File: rtl/wpb_fifo.sv
module wpb_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DATA_W-1:0]          push_data,
  input  logic                       pop,
  output logic [DATA_W-1:0]          pop_data,
  output logic [$clog2(DEPTH+1)-1:0] occ,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     occ_q;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign pop_data = mem[rd_ptr];
  assign occ      = occ_q;
  assign full     = (occ_q == CW'(DEPTH));
  assign empty    = (occ_q == '0);

endmodule

// File: rtl/wpb_gate.sv
module wpb_gate import wpb_pkg::*; #(
  parameter int LINE_BEATS = 8,
  parameter int CNT_W      = 7
) (
  input  logic             post_en,
  input  logic [1:0]       lvl,
  input  logic             first,
  input  logic             flush,
  input  logic [CNT_W-1:0] occ,
  output logic             launch,
  output logic             line_sel
);
  logic [CNT_W-1:0] need_tab [LVL_CODES];
  logic [CNT_W-1:0] need_now;
  logic             has_line, has_any;

  // Level code g asks for (LVL_CODES - g) full lines before the first burst
  genvar g;
  for (g = 0; g < int'(LVL_CODES); g++) begin : g_need
    assign need_tab[g] = CNT_W'((int'(LVL_CODES) - g) * LINE_BEATS);
  end

  assign need_now = first ? need_tab[lvl] : CNT_W'(LINE_BEATS);
  assign has_line = (occ >= CNT_W'(LINE_BEATS));
  assign has_any  = (occ != '0);

  always_comb begin
    launch   = 1'b0;
    line_sel = 1'b0;
    if (!post_en) begin
      launch = has_any;
    end else if ((occ >= need_now) || (flush && has_line)) begin
      launch   = 1'b1;
      line_sel = 1'b1;
    end else if (flush && has_any) begin
      launch = 1'b1;
    end
  end

endmodule

// File: rtl/wpb_master.sv
module wpb_master import wpb_pkg::*; #(
  parameter int LINE_BEATS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic line_sel,
  input  logic bus_gnt,
  output logic bus_req,
  output logic beat_en,
  output logic beat_last,
  output logic busy
);
  localparam int BW = $clog2(LINE_BEATS + 1);

  mst_state_e    state;
  logic [BW-1:0] len_q, beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= MS_IDLE;
      len_q  <= '0;
      beat_q <= '0;
    end else begin
      case (state)
        MS_IDLE: if (launch) begin
          state <= MS_REQ;
          len_q <= line_sel ? BW'(LINE_BEATS) : BW'(1);
        end
        MS_REQ: if (bus_gnt) begin
          state  <= MS_BURST;
          beat_q <= '0;
        end
        MS_BURST: begin
          beat_q <= beat_q + 1'b1;
          if (beat_last) state <= MS_IDLE;
        end
        default: state <= MS_IDLE;
      endcase
    end
  end

  assign bus_req   = (state == MS_REQ);
  assign beat_en   = (state == MS_BURST);
  assign beat_last = beat_en && (beat_q == len_q - 1'b1);
  assign busy      = (state != MS_IDLE);

endmodule

// File: rtl/posted_write_buffer.sv
module posted_write_buffer import wpb_pkg::*; #(
  parameter int DATA_W     = 32,
  parameter int LINE_BEATS = 8,
  parameter int LINES      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_post_en,
  input  logic [1:0]        cfg_start_lvl,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);
  localparam int DEPTH = LINE_BEATS * LINES;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] occ;
  logic             full, empty, push, pop, busy;
  logic             launch, line_sel;
  logic             cfg_en_q;
  logic [1:0]       cfg_lvl_q;
  logic             first_q, flush_q;
  logic             empty_idle;

  assign empty_idle = empty && !busy;
  assign in_ready   = !full && !flush_q;
  assign push       = in_valid && in_ready;

  // Settings latch plus transfer-phase flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_en_q  <= 1'b0;
      cfg_lvl_q <= 2'b00;
      first_q   <= 1'b1;
      flush_q   <= 1'b0;
    end else begin
      if (empty_idle) begin
        cfg_en_q  <= cfg_post_en;
        cfg_lvl_q <= cfg_start_lvl;
        first_q   <= 1'b1;
      end else if (launch && !busy) begin
        first_q <= 1'b0;
      end
      if (push && in_last)  flush_q <= 1'b1;
      else if (empty_idle)  flush_q <= 1'b0;
    end
  end

  wpb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(in_data),
    .pop(pop), .pop_data(out_data),
    .occ(occ), .full(full), .empty(empty)
  );

  wpb_gate #(.LINE_BEATS(LINE_BEATS), .CNT_W(CNT_W)) u_gate (
    .post_en(cfg_en_q), .lvl(cfg_lvl_q),
    .first(first_q), .flush(flush_q), .occ(occ),
    .launch(launch), .line_sel(line_sel)
  );

  wpb_master #(.LINE_BEATS(LINE_BEATS)) u_master (
    .clk(clk), .rst_n(rst_n),
    .launch(launch), .line_sel(line_sel),
    .bus_gnt(bus_gnt), .bus_req(bus_req),
    .beat_en(pop), .beat_last(out_last), .busy(busy)
  );

  assign out_valid = pop;

endmodule

// File: rtl/wpb_chk.sv
module wpb_chk #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             out_valid,
  input logic             out_last,
  input logic             cfg_en_q,
  input logic [1:0]       cfg_lvl_q,
  input logic             empty_idle,
  input logic [CNT_W-1:0] occ
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !in_ready);

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ != '0));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  // R10
  gnt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(bus_gnt));

  // R10
  req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !bus_req);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_idle |=> $stable({cfg_en_q, cfg_lvl_q}));

  // R7
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en_q && out_valid) |-> out_last);

endmodule

bind posted_write_buffer wpb_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .bus_req(bus_req), .bus_gnt(bus_gnt),
  .out_valid(out_valid), .out_last(out_last),
  .cfg_en_q(cfg_en_q), .cfg_lvl_q(cfg_lvl_q),
  .empty_idle(empty_idle), .occ(occ)
);

// File: tb/posted_write_buffer_tb.sv
module posted_write_buffer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_post_en = 1'b0;
  logic [1:0]  cfg_start_lvl = 2'b00;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready, bus_req, out_valid, out_last;
  logic        bus_gnt = 1'b0;
  logic [31:0] out_data;

  int total = 0, fails = 0;
  int seq_wr = 0, seq_rd = 0, nb = 0, cur_len = 0;
  int lens [256];

  always #4 clk = ~clk;

  posted_write_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_post_en(cfg_post_en), .cfg_start_lvl(cfg_start_lvl),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Output monitor: data order (R2) and burst lengths
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      chk(out_data == 32'h5A00_0000 + seq_rd, "R2", int'(out_data), 32'h5A00_0000 + seq_rd);
      seq_rd++;
      cur_len++;
      if (out_last) begin
        lens[nb] = cur_len;
        nb++;
        cur_len = 0;
      end
    end
  end

  task automatic push_word(input bit last);
    in_valid = 1'b1;
    in_data  = 32'h5A00_0000 + seq_wr;
    in_last  = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    seq_wr++;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic grant_once(input int lat);
    int target;
    target = nb + 1;
    while (!bus_req) @(negedge clk);
    repeat (lat) @(negedge clk);
    chk(bus_req == 1'b1, "R10 req held", int'(bus_req), 1);
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
    chk(out_valid == 1'b1 && bus_req == 1'b0, "R10 beat after grant", int'(out_valid), 1);
    while (nb < target) @(negedge clk);
  endtask

  task automatic run_cfg(input bit en, input int lvl);
    int need, step, rem, nb0, lines_exp, expl;
    need = en ? (4 - lvl) * 8 : 1;
    step = en ? 8 : 1;
    cfg_post_en   = en;
    cfg_start_lvl = 2'(lvl);
    repeat (3) @(negedge clk);
    for (int k = 1; k <= need; k++) begin
      push_word(1'b0);
      repeat (3) @(negedge clk);
      chk(bus_req == (k >= need), en ? "R4 start level" : "R7 single start",
          int'(bus_req), int'(k >= need));
    end
    nb0 = nb;
    grant_once(0);
    chk(lens[nb0] == step, en ? "R6 line burst" : "R7 single beat", lens[nb0], step);
    rem = need - step;
    repeat (3) @(negedge clk);
    chk(bus_req == (rem >= step), "R5 continuation", int'(bus_req), int'(rem >= step));
    push_word(1'b0);
    push_word(1'b0);
    push_word(1'b1);
    chk(in_ready == 1'b0, "R8 stall after last", int'(in_ready), 0);
    nb0 = nb;
    while (seq_rd < seq_wr) grant_once(0);
    lines_exp = en ? rem / 8 : 0;
    chk(nb - nb0 == lines_exp + 3, "R8 flush count", nb - nb0, lines_exp + 3);
    for (int j = 0; j < lines_exp + 3; j++) begin
      expl = (j < lines_exp) ? 8 : 1;
      chk(lens[nb0 + j] == expl, "R8 flush length", lens[nb0 + j], expl);
    end
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R8 ready after flush", int'(in_ready), 1);
  endtask

  initial begin
    int nb0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(bus_req == 1'b0, "R1 req", int'(bus_req), 0);
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);

    // Sweep: both enable settings, all level codes
    for (int l = 0; l < 4; l++) run_cfg(1'b1, l);
    for (int l = 0; l < 4; l++) run_cfg(1'b0, l);

    // R9: settings change mid-fill is ignored
    cfg_post_en = 1'b1; cfg_start_lvl = 2'b11;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) push_word(1'b0);
    cfg_post_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(bus_req == 1'b0, "R9 no early req", int'(bus_req), 0);
    for (int k = 0; k < 4; k++) push_word(1'b0);
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b1, "R9 old level kept", int'(bus_req), 1);
    nb0 = nb;
    grant_once(2);
    chk(lens[nb0] == 8, "R9 old mode burst", lens[nb0], 8);
    repeat (3) @(negedge clk);
    push_word(1'b0);
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b1, "R7 new mode taken when empty", int'(bus_req), 1);
    nb0 = nb;
    grant_once(1);
    chk(lens[nb0] == 1, "R7 new mode single", lens[nb0], 1);

    // R3: fill to capacity with no grant, then stall and release
    cfg_post_en = 1'b1; cfg_start_lvl = 2'b00;
    repeat (3) @(negedge clk);
    seq_wr = 0; seq_rd = 0;
    nb0 = nb;
    for (int k = 0; k < 64; k++) push_word(1'b0);
    chk(in_ready == 1'b0, "R3 full stall", int'(in_ready), 0);
    fork
      begin
        for (int k = 64; k < 70; k++) push_word(k == 69);
      end
      begin
        repeat (10) @(negedge clk);
        chk(seq_wr == 64, "R3 held while full", seq_wr, 64);
        while (seq_rd < 70) grant_once(3);
      end
    join
    chk(seq_wr == 70, "R3 stalled beats accepted", seq_wr, 70);
    chk(nb - nb0 == 14, "R8 burst split", nb - nb0, 14);
    for (int j = 0; j < 14; j++)
      chk(lens[nb0 + j] == ((j < 8) ? 8 : 1), "R6 R8 lengths", lens[nb0 + j], (j < 8) ? 8 : 1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule